// File: doc/BRIEF.md
# Nine-Candidate Best-Three Muon Track Selector

The selector receives nine assembled track candidates every clock, arranged as three streams of three (streams 0 and 1 are keyed on station 2, stream 2 on station 3). Each candidate has a 6-bit quality, a 9-bit hit identifier, a 4-bit track mode and a 4-bit crossing-tag word with one bit per stub. Every unordered pair of candidates is compared twice: once on quality and once on shared segments. When two candidates share a segment, the weaker one is removed, so that one muon cannot produce two triggers.

The survivors are ranked by quality. The best three are written to three output slots. Each slot carries a valid flag, a 17-bit descriptor built from the winner's stub numbers and mode, and the winner's crossing tags. The block is fully pipelined: it takes a new set of nine candidates every clock and answers two clocks later.

Top module: `trk_final_sel`

## Requirements
- R1: A candidate whose quality is 0 or whose mode is 0 is invalid. An invalid candidate never appears in an output slot and never removes another candidate.
- R2: The hit identifier holds three 3-bit segment fields: bits [8:6], [5:3] and [2:0]. Two valid candidates overlap when, at the same field position, the two values are equal and non-zero.
- R3: For every overlapping pair, the weaker candidate is removed. A removed candidate still removes weaker candidates that it overlaps, so the removal is strictly pairwise. No two surviving candidates overlap.
- R4: Candidate index is stream*3 + position. When two candidates have equal quality, the lower index counts as stronger, both for removal and for ranking.
- R5: Slot 0 holds the strongest survivor, slot 1 the next and slot 2 the third. When fewer than three candidates survive, the unused upper slots have their valid flag at 0. The valid flags are always filled from slot 0 upward.
- R6: The descriptor of slot k is out_desc[17k+16:17k], laid out as follows. Bits [16:12], [11:7] and [6:2] are stub numbers 1, 2 and 3. Each stub number is {2-bit stream index, segment field}, using hit fields [8:6], [5:3] and [2:0] in that order. Bit 1 is the two-station flag and bit 0 is the overlap-region flag. An empty slot outputs an all-zero descriptor and an all-zero tag word.
- R7: The two-station flag is 1 exactly for modes 6 to 10 and modes 14 and 15. The overlap-region flag is 1 exactly for modes 11 to 15.
- R8: out_tag[4k+3:4k] is the crossing-tag word of the candidate in slot k, passed through unchanged.
- R9: Inputs sampled at clock edge n appear on the outputs after edge n+2. A new input set is accepted at every edge.
- R10: While rst_n is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_qual | input | 54 | Quality of candidate c at [6c+5:6c] |
| in_hit | input | 81 | Hit identifier of candidate c at [9c+8:9c] |
| in_mode | input | 36 | Track mode of candidate c at [4c+3:4c] |
| in_tag | input | 36 | Crossing tags of candidate c at [4c+3:4c] |
| out_valid | output | 3 | Slot valid flags, bit k for slot k |
| out_desc | output | 51 | Packed descriptors, 17 bits per slot |
| out_tag | output | 12 | Crossing-tag words, 4 bits per slot |

## Verification
The random stimulus draws segment fields from a small alphabet. This makes overlaps, removal chains and equal qualities frequent, so ranking errors and removal errors show up as differences in which candidate occupies each slot. Directed cases separate the remaining behaviours:
- invalid candidates that overlap valid ones, which shows whether invalid candidates can remove others;
- a three-candidate removal chain, which shows strictly pairwise removal apart from transitive removal;
- equal-quality pairs, which check the index tie-break;
- non-zero segment values at different field positions, which must not count as an overlap;
- a sweep of all fifteen modes through one candidate, which checks the two descriptor flags.

// File: rtl/trk_sel_pkg.sv
package trk_sel_pkg;

  localparam int QW    = 6;            // quality width
  localparam int FW    = 3;            // segment field width
  localparam int NF    = 3;            // segment fields per hit identifier
  localparam int HW    = NF * FW;      // hit identifier width
  localparam int MW    = 4;            // track mode width
  localparam int TW    = 4;            // crossing-tag word width
  localparam int SIDW  = 2;            // stream index width in a stub number
  localparam int SW    = SIDW + FW;    // stub number width
  localparam int DW    = NF * SW + 2;  // descriptor width

  typedef logic [QW-1:0] qual_t;
  typedef logic [HW-1:0] hit_t;
  typedef logic [MW-1:0] mode_t;
  typedef logic [DW-1:0] desc_t;

  // a candidate takes part only with non-zero quality and mode
  function automatic logic cand_ok(qual_t q, mode_t m);
    return (q != '0) && (m != '0);
  endfunction

  // same non-zero segment value at the same field position
  function automatic logic hits_share(hit_t a, hit_t b);
    logic r;
    r = 1'b0;
    for (int f = 0; f < NF; f++) begin
      if ((a[f*FW +: FW] == b[f*FW +: FW]) && (a[f*FW +: FW] != '0)) r = 1'b1;
    end
    return r;
  endfunction

  function automatic logic mode_two_stn(mode_t m);
    return ((m >= 4'd6) && (m <= 4'd10)) || (m >= 4'd14);
  endfunction

  function automatic logic mode_overlap(mode_t m);
    return m >= 4'd11;
  endfunction

  function automatic desc_t pack_desc(logic [SIDW-1:0] sid, hit_t h, mode_t m);
    desc_t d;
    for (int f = 0; f < NF; f++) begin
      d[DW-1-f*SW -: SW] = {sid, h[HW-1-f*FW -: FW]};
    end
    d[1] = mode_two_stn(m);
    d[0] = mode_overlap(m);
    return d;
  endfunction

endpackage

// File: rtl/trk_pair_cmp.sv
module trk_pair_cmp
  import trk_sel_pkg::*;
#(
  parameter int NC = 9
) (
  input  logic [NC*QW-1:0] qual,
  input  logic [NC*HW-1:0] hit,
  input  logic [NC*MW-1:0] mode,
  output logic [NC-1:0]    valid,
  output logic [NC*NC-1:0] beats,   // [i*NC+j]: i stronger than j
  output logic [NC*NC-1:0] share    // [i*NC+j]: valid pair with common segment
);

  for (genvar c = 0; c < NC; c++) begin : g_valid
    assign valid[c] = cand_ok(qual[c*QW +: QW], mode[c*MW +: MW]);
  end

  for (genvar i = 0; i < NC; i++) begin : g_row
    for (genvar j = 0; j < NC; j++) begin : g_col
      if (i == j) begin : g_diag
        assign beats[i*NC+j] = 1'b0;
        assign share[i*NC+j] = 1'b0;
      end else if (i < j) begin : g_pair
        logic q_ge;
        logic h_sh;
        // lower index keeps the tie
        assign q_ge = qual[i*QW +: QW] >= qual[j*QW +: QW];
        assign h_sh = valid[i] & valid[j] & hits_share(hit[i*HW +: HW], hit[j*HW +: HW]);
        assign beats[i*NC+j] = q_ge;
        assign beats[j*NC+i] = ~q_ge;
        assign share[i*NC+j] = h_sh;
        assign share[j*NC+i] = h_sh;
      end
    end
  end

endmodule

// File: rtl/trk_cancel_rank.sv
module trk_cancel_rank
  import trk_sel_pkg::*;
#(
  parameter int NC = 9,
  parameter int RW = $clog2(NC + 1)
) (
  input  logic [NC-1:0]    valid,
  input  logic [NC*NC-1:0] beats,
  input  logic [NC*NC-1:0] share,
  output logic [NC-1:0]    surv,
  output logic [NC*RW-1:0] rank
);

  for (genvar i = 0; i < NC; i++) begin : g_kill
    logic [NC-1:0] killer;
    for (genvar j = 0; j < NC; j++) begin : g_k
      assign killer[j] = share[j*NC+i] & beats[j*NC+i];
    end
    assign surv[i] = valid[i] & ~(|killer);
  end

  for (genvar i = 0; i < NC; i++) begin : g_rank
    logic [NC-1:0] above;
    for (genvar j = 0; j < NC; j++) begin : g_a
      assign above[j] = surv[j] & beats[j*NC+i];
    end
    assign rank[i*RW +: RW] = RW'($countones(above));
  end

endmodule

// File: rtl/trk_slot_mux.sv
module trk_slot_mux
  import trk_sel_pkg::*;
#(
  parameter int NC = 9,
  parameter int PS = 3,
  parameter int NO = 3,
  parameter int RW = $clog2(NC + 1)
) (
  input  logic [NC-1:0]    surv,
  input  logic [NC*RW-1:0] rank,
  input  logic [NC*HW-1:0] hit,
  input  logic [NC*MW-1:0] mode,
  input  logic [NC*TW-1:0] tag,
  output logic [NO*NC-1:0] slot_sel,
  output logic [NO-1:0]    slot_vld,
  output logic [NO*DW-1:0] slot_desc,
  output logic [NO*TW-1:0] slot_tag
);

  for (genvar k = 0; k < NO; k++) begin : g_slot
    for (genvar c = 0; c < NC; c++) begin : g_m
      assign slot_sel[k*NC+c] = surv[c] && (rank[c*RW +: RW] == RW'(k));
    end

    assign slot_vld[k] = |slot_sel[k*NC +: NC];

    always_comb begin
      slot_desc[k*DW +: DW] = '0;
      slot_tag[k*TW +: TW]  = '0;
      for (int c = 0; c < NC; c++) begin
        if (slot_sel[k*NC+c]) begin
          slot_desc[k*DW +: DW] = slot_desc[k*DW +: DW] |
            pack_desc(SIDW'(c / PS), hit[c*HW +: HW], mode[c*MW +: MW]);
          slot_tag[k*TW +: TW] = slot_tag[k*TW +: TW] | tag[c*TW +: TW];
        end
      end
    end
  end

endmodule

// File: rtl/trk_final_sel.sv
module trk_final_sel
  import trk_sel_pkg::*;
#(
  parameter int NS = 3,
  parameter int PS = 3,
  parameter int NO = 3,
  localparam int NC = NS * PS,
  localparam int RW = $clog2(NC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NC*QW-1:0] in_qual,
  input  logic [NC*HW-1:0] in_hit,
  input  logic [NC*MW-1:0] in_mode,
  input  logic [NC*TW-1:0] in_tag,
  output logic [NO-1:0]    out_valid,
  output logic [NO*DW-1:0] out_desc,
  output logic [NO*TW-1:0] out_tag
);

  logic [NC-1:0]    cand_vld;
  logic [NC*NC-1:0] beats;
  logic [NC*NC-1:0] share;
  logic [NC-1:0]    surv_d;
  logic [NC*RW-1:0] rank_d;

  trk_pair_cmp #(.NC(NC)) cmp_i (
    .qual (in_qual),
    .hit  (in_hit),
    .mode (in_mode),
    .valid(cand_vld),
    .beats(beats),
    .share(share)
  );

  trk_cancel_rank #(.NC(NC), .RW(RW)) crk_i (
    .valid(cand_vld),
    .beats(beats),
    .share(share),
    .surv (surv_d),
    .rank (rank_d)
  );

  // stage 1: survivors and ranks with the payload they select from
  logic [NC-1:0]    surv_q;
  logic [NC*RW-1:0] rank_q;
  logic [NC*HW-1:0] hit_q;
  logic [NC*MW-1:0] mode_q;
  logic [NC*TW-1:0] tag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      surv_q <= '0;
      rank_q <= '0;
      hit_q  <= '0;
      mode_q <= '0;
      tag_q  <= '0;
    end else begin
      surv_q <= surv_d;
      rank_q <= rank_d;
      hit_q  <= in_hit;
      mode_q <= in_mode;
      tag_q  <= in_tag;
    end
  end

  logic [NO*NC-1:0] slot_sel;
  logic [NO-1:0]    slot_vld;
  logic [NO*DW-1:0] slot_desc;
  logic [NO*TW-1:0] slot_tag;

  trk_slot_mux #(.NC(NC), .PS(PS), .NO(NO), .RW(RW)) mux_i (
    .surv     (surv_q),
    .rank     (rank_q),
    .hit      (hit_q),
    .mode     (mode_q),
    .tag      (tag_q),
    .slot_sel (slot_sel),
    .slot_vld (slot_vld),
    .slot_desc(slot_desc),
    .slot_tag (slot_tag)
  );

  // stage 2: output registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= '0;
      out_desc  <= '0;
      out_tag   <= '0;
    end else begin
      out_valid <= slot_vld;
      out_desc  <= slot_desc;
      out_tag   <= slot_tag;
    end
  end

endmodule

// File: rtl/trk_final_sel_chk.sv
module trk_final_sel_chk
  import trk_sel_pkg::*;
#(
  parameter int NC = 9,
  parameter int NO = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NC*QW-1:0] in_qual,
  input logic [NC*MW-1:0] in_mode,
  input logic [NC-1:0]    surv_q,
  input logic [NC*HW-1:0] hit_q,
  input logic [NO*NC-1:0] slot_sel,
  input logic [NO-1:0]    out_valid,
  input logic [NO*DW-1:0] out_desc,
  input logic [NO*TW-1:0] out_tag
);

  logic [NC-1:0] in_ok;
  logic          any_in_ok;
  logic          surv_clash;
  logic [1:0]    run_cnt;

  for (genvar c = 0; c < NC; c++) begin : g_ok
    assign in_ok[c] = cand_ok(in_qual[c*QW +: QW], in_mode[c*MW +: MW]);
  end
  assign any_in_ok = |in_ok;

  always_comb begin
    surv_clash = 1'b0;
    for (int i = 0; i < NC; i++) begin
      for (int j = i + 1; j < NC; j++) begin
        if (surv_q[i] && surv_q[j] && hits_share(hit_q[i*HW +: HW], hit_q[j*HW +: HW]))
          surv_clash = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_cnt <= '0;
    else if (run_cnt != 2'd2) run_cnt <= run_cnt + 2'd1;
  end

  for (genvar c = 0; c < NC; c++) begin : g_surv
    AST_SURV_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      surv_q[c] |-> $past(in_ok[c])); // R1
  end

  AST_SURV_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    !surv_clash); // R3

  for (genvar k = 0; k < NO; k++) begin : g_slot
    AST_SLOT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(slot_sel[k*NC +: NC])); // R5
    AST_EMPTY_SLOT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid[k] |-> (out_desc[k*DW +: DW] == '0 && out_tag[k*TW +: TW] == '0)); // R6
    if (k > 0) begin : g_pack
      AST_VALID_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid[k] |-> out_valid[k-1]); // R5
    end
  end

  AST_FIRST_SLOT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (run_cnt == 2'd2) |-> (out_valid[0] == $past(any_in_ok, 2))); // R9

endmodule

bind trk_final_sel trk_final_sel_chk #(.NC(NC), .NO(NO)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_qual  (in_qual),
  .in_mode  (in_mode),
  .surv_q   (surv_q),
  .hit_q    (hit_q),
  .slot_sel (slot_sel),
  .out_valid(out_valid),
  .out_desc (out_desc),
  .out_tag  (out_tag)
);

// File: tb/trk_final_sel_tb.sv
`timescale 1ns/1ps
module trk_final_sel_tb_top;

  localparam int NC = 9;
  localparam int NO = 3;

  typedef struct packed {
    logic [2:0]  v;
    logic [50:0] d;
    logic [11:0] t;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [53:0]  in_qual = '0;
  logic [80:0]  in_hit = '0;
  logic [35:0]  in_mode = '0;
  logic [35:0]  in_tag = '0;
  logic [2:0]   out_valid;
  logic [50:0]  out_desc;
  logic [11:0]  out_tag;

  int errors = 0;
  int checks = 0;

  logic [5:0] cq [NC];
  logic [8:0] ch [NC];
  logic [3:0] cm [NC];
  logic [3:0] ct [NC];

  exp_t  e0, e1;
  string l0, l1;

  always #10 clk = ~clk;

  trk_final_sel dut_i (
    .clk(clk), .rst_n(rst_n), .in_qual(in_qual), .in_hit(in_hit),
    .in_mode(in_mode), .in_tag(in_tag), .out_valid(out_valid),
    .out_desc(out_desc), .out_tag(out_tag)
  );

  function automatic bit tb_overlap(logic [8:0] a, logic [8:0] b);
    for (int f = 0; f < 3; f++) begin
      logic [8:0] fa, fb;
      fa = (a >> (3 * f)) & 9'd7;
      fb = (b >> (3 * f)) & 9'd7;
      if (fa != 0 && fa == fb) return 1'b1;
    end
    return 1'b0;
  endfunction

  function automatic logic [16:0] tb_desc(int c);
    logic [1:0] s;
    logic two, ovl;
    s = 2'(c / 3);
    case (cm[c])
      4'd6, 4'd7, 4'd8, 4'd9, 4'd10, 4'd14, 4'd15: two = 1'b1;
      default: two = 1'b0;
    endcase
    ovl = (cm[c] > 4'd10);
    return {s, ch[c][8:6], s, ch[c][5:3], s, ch[c][2:0], two, ovl};
  endfunction

  function automatic exp_t model();
    exp_t e;
    bit ok [NC];
    bit alive [NC];
    bit taken [NC];
    e = '0;
    for (int i = 0; i < NC; i++) begin
      ok[i] = (cq[i] != 0) && (cm[i] != 0);
      taken[i] = 1'b0;
    end
    for (int i = 0; i < NC; i++) begin
      alive[i] = ok[i];
      for (int j = 0; j < NC; j++) begin
        if (j != i && ok[j] && ok[i] && tb_overlap(ch[i], ch[j]) &&
            (cq[j] > cq[i] || (cq[j] == cq[i] && j < i)))
          alive[i] = 1'b0;
      end
    end
    for (int k = 0; k < NO; k++) begin
      int best;
      best = -1;
      for (int c = 0; c < NC; c++) begin
        if (alive[c] && !taken[c] && (best < 0 || cq[c] > cq[best])) best = c;
      end
      if (best >= 0) begin
        taken[best] = 1'b1;
        e.v[k] = 1'b1;
        e.d[k*17 +: 17] = tb_desc(best);
        e.t[k*4 +: 4] = ct[best];
      end
    end
    return e;
  endfunction

  task automatic fail_line(string lbl, string what, logic [16:0] got, logic [16:0] exp);
    errors++;
    $display("FAIL %s %s: got %0h exp %0h", lbl, what, got, exp);
  endtask

  task automatic compare(exp_t e, string lbl);
    for (int k = 0; k < NO; k++) begin
      checks++;
      if (out_valid[k] !== e.v[k])
        fail_line(lbl, $sformatf("slot%0d valid R5", k), 17'(out_valid[k]), 17'(e.v[k]));
      checks++;
      if (out_desc[k*17 +: 17] !== e.d[k*17 +: 17])
        fail_line(lbl, $sformatf("slot%0d desc R6", k), out_desc[k*17 +: 17], e.d[k*17 +: 17]);
      checks++;
      if (out_tag[k*4 +: 4] !== e.t[k*4 +: 4])
        fail_line(lbl, $sformatf("slot%0d tag R8", k), 17'(out_tag[k*4 +: 4]), 17'(e.t[k*4 +: 4]));
    end
  endtask

  task automatic drive();
    for (int c = 0; c < NC; c++) begin
      in_qual[c*6 +: 6] = cq[c];
      in_hit[c*9 +: 9]  = ch[c];
      in_mode[c*4 +: 4] = cm[c];
      in_tag[c*4 +: 4]  = ct[c];
    end
  endtask

  task automatic clear();
    for (int c = 0; c < NC; c++) begin
      cq[c] = '0; ch[c] = '0; cm[c] = '0; ct[c] = '0;
    end
  endtask

  task automatic setc(int c, logic [5:0] q, logic [8:0] h, logic [3:0] m, logic [3:0] t);
    cq[c] = q; ch[c] = h; cm[c] = m; ct[c] = t;
  endtask

  // R9: compare against the set driven two negedges earlier, then drive next
  task automatic step(string lbl);
    @(negedge clk);
    compare(e1, l1);
    e1 = e0; l1 = l0;
    drive();
    e0 = model();
    l0 = lbl;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    // R10: valid inputs during reset, outputs held at zero
    clear();
    for (int c = 0; c < NC; c++) setc(c, 6'(c + 5), 9'(c * 73 + 1), 4'd2, 4'hf);
    drive();
    for (int n = 0; n < 3; n++) begin
      @(negedge clk);
      compare('0, "R10 reset");
    end
    @(negedge clk);
    clear();
    drive();
    rst_n = 1'b1;
    e0 = '0; e1 = '0; l0 = "R10 after reset"; l1 = "R10 after reset";

    // R1: nothing valid, hits present
    clear();
    for (int c = 0; c < NC; c++) setc(c, 6'd0, 9'b001_001_001, 4'd3, 4'h5);
    step("R1 all invalid");

    // R1: invalid candidates overlapping a valid one remove nothing
    clear();
    setc(0, 6'd0,  9'b001_001_001, 4'd5, 4'h1);
    setc(1, 6'd10, 9'b001_001_001, 4'd2, 4'h6);
    setc(2, 6'd20, 9'b001_001_001, 4'd0, 4'h3);
    step("R1 invalid cannot cancel");

    // R3: chain c0 > c1 > c2, c0 and c2 disjoint; c2 still removed by c1
    clear();
    setc(0, 6'd50, 9'b001_000_000, 4'd2, 4'h1);
    setc(1, 6'd40, 9'b001_010_000, 4'd3, 4'h2);
    setc(2, 6'd30, 9'b000_010_000, 4'd4, 4'h4);
    setc(4, 6'd20, 9'b011_011_011, 4'd6, 4'h8);
    step("R3 pairwise chain");

    // R4: equal quality, lower index wins removal and ranking
    clear();
    setc(3, 6'd33, 9'b000_000_101, 4'd2, 4'h3);
    setc(7, 6'd33, 9'b110_000_101, 4'd5, 4'hc);
    setc(5, 6'd33, 9'b010_010_010, 4'd11, 4'h9);
    step("R4 tie break");

    // R2: equal values at different fields and zero fields do not overlap
    clear();
    setc(0, 6'd9,  9'b001_000_000, 4'd2, 4'h1);
    setc(1, 6'd12, 9'b000_001_000, 4'd2, 4'h2);
    setc(8, 6'd15, 9'b000_000_001, 4'd7, 4'h4);
    step("R2 field position");

    // R5: five disjoint survivors, only the best three reported
    clear();
    for (int c = 0; c < 5; c++) setc(c * 2, 6'(10 + c * 7), 9'({3'(c + 1), 3'(c + 1), 3'(c + 1)}), 4'd2, 4'(c));
    step("R5 top three of five");

    // R7: every mode through one stream-2 candidate
    for (int m = 1; m < 16; m++) begin
      clear();
      setc(8, 6'd44, 9'b101_011_110, 4'(m), 4'(m));
      step("R7 mode sweep");
    end

    // R3 R4 R5 R6 R8 R9: random back-to-back sets with frequent overlaps
    for (int n = 0; n < 3000; n++) begin
      for (int c = 0; c < NC; c++) begin
        logic [5:0] q;
        q = 6'($urandom % 64);
        if ($urandom % 8 == 0) q = 6'd0;
        if ($urandom % 4 == 0) q = 6'(20 + $urandom % 4);
        setc(c, q, 9'({3'($urandom % 4), 3'($urandom % 4), 3'($urandom % 4)}),
             4'($urandom % 16), 4'($urandom % 16));
      end
      step("R3 R4 R5 R6 R8 R9 random");
    end

    clear();
    step("R9 flush");
    step("R9 flush");
    step("R9 flush");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule